// File: doc/BRIEF.md
# Pipelined Integer Square Root

This block takes an unsigned radicand of 2N bits and returns its integer square root (N bits) and the remainder (N+1 bits). The arithmetic is spread over N registered stages. Each stage settles one root bit, starting with the most significant one, and takes in the next two radicand bits.

Every stage does a single trial subtraction. The trial value is the partial root with binary 01 appended. The borrow of that subtraction picks the stage's remainder: either the difference or the unchanged shifted remainder. No stage ever adds a value back, and no stage uses a 11 suffix.

The pipeline takes a new radicand on every clock. Each result comes out with a matching valid flag a fixed N cycles after its input. Idle slots travel through the pipeline as invalid slots.

Top module: `isqrt_pipe`

## Requirements
- R1: Parameter N (default 8) sets the radicand width to 2N bits, the root width to N bits and the remainder width to N+1 bits.
- R2: A synchronous active-high reset clears every stage's valid flag, so out_valid is low in the cycle after reset.
- R3: A radicand sampled with in_valid high at a rising edge appears with out_valid high exactly N rising edges later. A new radicand is accepted at every edge.
- R4: For every valid result, out_root*out_root + out_rem equals the radicand and out_rem <= 2*out_root.
- R5: Stages consume two-bit radicand groups from the most significant end. A root bit is 1 exactly when (partial root * 4 + 1) <= the shifted partial remainder, and then the difference becomes the remainder. Otherwise the remainder passes unchanged.
- R6: The root's most significant bit is 1 exactly when the top two radicand bits are not both zero.
- R7: Radicand 93 gives root 9 and remainder 12.
- R8: The all-ones radicand gives an all-ones root and a remainder of twice the root.
- R9: Radicand 0 gives root 0 and remainder 0.
- R10: A cycle with in_valid low produces a cycle N edges later with out_valid low, even when valid inputs sit on either side of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Radicand strobe |
| in_radicand | input | 2N | Unsigned radicand |
| out_valid | output | 1 | Result strobe, N cycles after in_valid |
| out_root | output | N | Integer square root |
| out_rem | output | N+1 | Radicand minus root squared |

## Verification
Two things can happen in the same cycle: a new radicand enters stage zero while an older result leaves the last stage, and in that cycle each stage's subtract-multiplex works on a different operand. Two copies are driven in lockstep: a four-bit-root copy that gets every radicand back to back, and an eight-bit-root copy that gets random radicands. Both are then fed streams in which valid and idle slots are interleaved at random. At each falling edge the bench looks up which input the output should carry, N edges back in its own history. It checks the valid flag against that input, and it checks the root and remainder against a square root found by incremental search.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  localparam int GROUP_W = 2;

  typedef enum logic {
    SEL_KEEP = 1'b0,
    SEL_TAKE = 1'b1
  } sel_e;
endpackage

// File: rtl/isqrt_csm.sv
module isqrt_csm #(
  parameter int N = 8
) (
  input  logic [N:0]   rem_i,
  input  logic [N-1:0] root_i,
  input  logic [1:0]   pair_i,
  output logic [N:0]   rem_o,
  output logic         bit_o,
  output logic [N+2:0] wide_o
);
  import isqrt_pkg::*;
  localparam int W = N + 3;

  function automatic logic [W-1:0] shift_in(logic [N:0] r, logic [1:0] p);
    return {r, p};
  endfunction

  function automatic logic [W-1:0] trial_of(logic [N-1:0] q);
    return {1'b0, q, 2'b01};
  endfunction

  logic [W-1:0] shifted;
  logic [W-1:0] trial;
  logic [W:0]   diff;
  logic         borrow;
  sel_e         sel;

  always_comb begin
    shifted = shift_in(rem_i, pair_i);
    trial   = trial_of(root_i);
    diff    = {1'b0, shifted} - {1'b0, trial};
    borrow  = diff[W];
    sel     = borrow ? SEL_KEEP : SEL_TAKE;
    wide_o  = (sel == SEL_TAKE) ? diff[W-1:0] : shifted;
    rem_o   = wide_o[N:0];
    bit_o   = (sel == SEL_TAKE);
  end
endmodule

// File: rtl/isqrt_stage.sv
module isqrt_stage #(
  parameter int N = 8,
  parameter int K = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [N:0]     rem_i,
  input  logic [N-1:0]   root_i,
  input  logic [2*N-1:0] rad_i,
  output logic           vld_q,
  output logic [N:0]     rem_q,
  output logic [N-1:0]   root_q,
  output logic [2*N-1:0] rad_q
);
  logic [N:0]   rem_nxt;
  logic         bit_nxt;
  logic [N+2:0] wide_rem;

  isqrt_csm #(.N(N)) cell_i (
    .rem_i  (rem_i),
    .root_i (root_i),
    .pair_i (rad_i[2*N-1 -: 2]),
    .rem_o  (rem_nxt),
    .bit_o  (bit_nxt),
    .wide_o (wide_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    rem_q  <= rem_nxt;
    root_q <= {root_i[N-2:0], bit_nxt};
    rad_q  <= {rad_i[2*N-3:0], 2'b00};
  end

  // R4: the selected remainder never needs more than N+1 bits
  a_r4_rem_narrow: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> (wide_rem[N+2:N+1] == 2'b00));

  // R4: partial remainder stays within twice the partial root
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ({1'b0, rem_q} <= {1'b0, root_q, 1'b0}));

  // R5: after stage K only K+1 root bits can be set
  a_r5_root_width: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ((root_q >> (K + 1)) == '0));
endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2*N-1:0] in_radicand,
  output logic           out_valid,
  output logic [N-1:0]   out_root,
  output logic [N:0]     out_rem
);
  logic           vld_p  [N+1];
  logic [N:0]     rem_p  [N+1];
  logic [N-1:0]   root_p [N+1];
  logic [2*N-1:0] rad_p  [N+1];

  assign vld_p[0]  = in_valid;
  assign rem_p[0]  = '0;
  assign root_p[0] = '0;
  assign rad_p[0]  = in_radicand;

  for (genvar k = 0; k < N; k++) begin : g_stage
    isqrt_stage #(.N(N), .K(k)) stage_i (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (vld_p[k]),
      .rem_i  (rem_p[k]),
      .root_i (root_p[k]),
      .rad_i  (rad_p[k]),
      .vld_q  (vld_p[k+1]),
      .rem_q  (rem_p[k+1]),
      .root_q (root_p[k+1]),
      .rad_q  (rad_p[k+1])
    );
  end

  assign out_valid = vld_p[N];
  assign out_root  = root_p[N];
  assign out_rem   = rem_p[N];

  logic first_bit;
  assign first_bit = root_p[1][0];

  // R2: no result is flagged in the cycle after reset
  a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R4: output remainder bounded by twice the root
  a_r4_out_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_rem} <= {1'b0, out_root, 1'b0}));

  // R5: every radicand group has been consumed at the output
  a_r5_groups_used: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rad_p[N] == '0));

  // R6: first root bit follows the top radicand group
  a_r6_first_bit: assert property (@(posedge clk) disable iff (rst)
    vld_p[1] |-> (first_bit == $past(in_radicand[2*N-1 -: 2] != 2'b00)));
endmodule

// File: tb/isqrt_pipe_tb_top.sv
module isqrt_pipe_tb_top;
  localparam int NS = 4;
  localparam int NW = 8;
  localparam int HD = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            v4 = 1'b0, v8 = 1'b0;
  logic [2*NS-1:0] d4 = '0;
  logic [2*NW-1:0] d8 = '0;
  logic            o4v, o8v;
  logic [NS-1:0]   o4r;
  logic [NS:0]     o4m;
  logic [NW-1:0]   o8r;
  logic [NW:0]     o8m;

  isqrt_pipe #(.N(NS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(v4), .in_radicand(d4),
    .out_valid(o4v), .out_root(o4r), .out_rem(o4m));

  isqrt_pipe #(.N(NW)) dut_w_i (
    .clk(clk), .rst(rst), .in_valid(v8), .in_radicand(d8),
    .out_valid(o8v), .out_root(o8r), .out_rem(o8m));

  bit h4v [HD];
  int h4d [HD];
  bit h8v [HD];
  int h8d [HD];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_sqrt(int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic judge(bit ev, int x, bit ov, int qr, int qm, int nb);
    int r;
    if (ev) chk("R3 valid", int'(ov), 1);
    else    chk("R10 idle", int'(ov), 0);
    if (ev && ov) begin
      r = ref_sqrt(x);
      chk("R4 root", qr, r);
      chk("R4 remainder", qm, x - r * r);
      chk("R5 maximal root", int'((qr + 1) * (qr + 1) > x), 1);
      chk("R6 top bit", (qr >> (nb - 1)) & 1, int'((x >> (2 * nb - 2)) != 0));
      if (x == 93) begin
        chk("R7 root", qr, 9);
        chk("R7 remainder", qm, 12);
      end
      if (x == (1 << (2 * nb)) - 1) begin
        chk("R8 root", qr, (1 << nb) - 1);
        chk("R8 remainder", qm, 2 * ((1 << nb) - 1));
      end
      if (x == 0) begin
        chk("R9 root", qr, 0);
        chk("R9 remainder", qm, 0);
      end
    end
  endtask

  task automatic step(bit a, int da, bit b, int db);
    int i4;
    int i8;
    @(negedge clk);
    cyc++;
    i4 = cyc - NS + 1;
    i8 = cyc - NW + 1;
    judge((i4 >= 1) ? h4v[i4 % HD] : 1'b0, h4d[((i4 % HD) + HD) % HD],
          o4v, int'(o4r), int'(o4m), NS);
    judge((i8 >= 1) ? h8v[i8 % HD] : 1'b0, h8d[((i8 % HD) + HD) % HD],
          o8v, int'(o8r), int'(o8m), NW);
    v4 = a;
    d4 = da[2*NS-1:0];
    v8 = b;
    d8 = db[2*NW-1:0];
    h4v[(cyc + 1) % HD] = a;
    h4d[(cyc + 1) % HD] = da & ((1 << (2 * NS)) - 1);
    h8v[(cyc + 1) % HD] = b;
    h8d[(cyc + 1) % HD] = db & ((1 << (2 * NW)) - 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < HD; i++) begin
      h4v[i] = 1'b0; h4d[i] = 0; h8v[i] = 1'b0; h8d[i] = 0;
    end
    repeat (3) step(1'b0, 0, 1'b0, 0);
    rst = 1'b0;
    chk("R2 reset small", int'(o4v), 0);
    chk("R2 reset wide", int'(o8v), 0);
    chk("R1 root width", $bits(o8r), NW);
    chk("R1 remainder width", $bits(o8m), NW + 1);
    // exhaustive back-to-back sweep on the small copy
    for (int i = 0; i < (1 << (2 * NS)); i++)
      step(1'b1, i, 1'b1, int'($urandom % 65536));
    // idle slots interleaved with valid ones
    for (int i = 0; i < 300; i++)
      step(1'($urandom % 2), int'($urandom % 256),
           1'($urandom % 2), int'($urandom % 65536));
    // corner radicands: R7, R8, R9
    step(1'b1, 93, 1'b1, 93);
    step(1'b1, 255, 1'b1, 65535);
    step(1'b0, 0, 1'b0, 0);
    step(1'b1, 0, 1'b1, 0);
    step(1'b1, 255, 1'b1, 65535);
    step(1'b1, 16, 1'b1, 16384);
    step(1'b1, 15, 1'b1, 16383);
    repeat (NW + 3) step(1'b0, 0, 1'b0, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule